// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block gathers single-cycle event strobes from the receive path into a primary flag byte. It combines that byte with an enable mask to drive an active-low interrupt pin. Each flag is cleared by the access that reports its cause: completing a window-data read command sequence, reading the status register, or reading the frame-information register. There is no generic write-one-to-clear. A second-level pair, made of one extended flag and its extended enable, feeds a summary bit in the primary byte.

The same pin also acts as the transaction handshake. When a command byte has been accepted and the block is ready for the payload transaction, the pin falls. Every completed transaction forces the pin high, and it stays high for a short guard interval. After that it falls again only if enabled flags are still pending or the handshake is still outstanding. This gives the master a distinct new falling edge. A flag whose enable is off still latches and can be read in the flag byte, but it never pulls the pin.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag byte reads 0x00, all enables are 0, and `irq_n_o` is high.
- R2: A strobe on `evt_frame`, `evt_lost`, `evt_win_chg`, `evt_link` or `evt_asc` sets flag bit 0, 1, 2, 3 or 4 respectively. The flag is visible in `flags_o` one clock later. Bit 5 always reads 0.
- R3: `dmx_read_done` clears bits 0 and 2 and leaves the other bits unchanged.
- R4: `rd_status` clears bits 1 and 3 and leaves the other bits unchanged.
- R5: `rd_frame_info` clears bit 4 and leaves the other bits unchanged.
- R6: When an event strobe and the clear for its flag arrive in the same cycle, the flag ends set.
- R7: `evt_meta` sets the extended flag, and `rd_ext_flags` clears it; the event wins a tie. Flag bit 6 reads 1 only while the extended flag is set and extended enable bit 6 (written through `ext_mask_wr`/`ext_mask_wdata[6]`) is 1.
- R8: `mask_wr` loads enable bits 0–4 and 6 from `mask_wdata`. When `txn_end` and `cmd_ack` have been idle, `irq_n_o` goes low one clock after any flag bit is set together with its enable. `irq_n_o` stays high while only disabled flags are set.
- R9: Flag bit 7 shows the `busy_i` level in the same cycle. Busy never drives the pin, even if mask bit 7 was written as 1.
- R10: `txn_end` makes `irq_n_o` high at the next clock edge and keeps it high for one more clock. On the edge after that, the pin falls if an enabled flag is pending or the payload handshake is outstanding.
- R11: `cmd_ack` makes the payload handshake outstanding, and this drives `irq_n_o` low with no pending flag. A later `txn_end` ends the handshake. If both arrive in the same cycle, the handshake stays outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_frame | input | 1 | Complete frame received strobe |
| evt_lost | input | 1 | Data stream lost strobe |
| evt_win_chg | input | 1 | Window contents changed strobe |
| evt_link | input | 1 | Link status changed strobe |
| evt_asc | input | 1 | Alternate-start-code frame received strobe |
| evt_meta | input | 1 | Metadata changed strobe (extended flag) |
| busy_i | input | 1 | Busy level from the transaction engine |
| mask_wr | input | 1 | Primary enable register write strobe |
| mask_wdata | input | 8 | Primary enable write data |
| ext_mask_wr | input | 1 | Extended enable register write strobe |
| ext_mask_wdata | input | 8 | Extended enable write data |
| dmx_read_done | input | 1 | Window-data read command sequence completed |
| rd_status | input | 1 | Status register read strobe |
| rd_frame_info | input | 1 | Frame-information register read strobe |
| rd_ext_flags | input | 1 | Extended flag register read strobe |
| txn_end | input | 1 | Successful end of a bus transaction |
| cmd_ack | input | 1 | Command byte accepted, ready for payload |
| flags_o | output | 8 | Primary flag byte |
| irq_n_o | output | 1 | Active-low interrupt / handshake pin |

## Verification
A flag bit that is stuck or cleared by the wrong access shows up in `flags_o` on the next clock. A wrong enable bit or a missed summary shows up at `irq_n_o` one clock after that. A broken guard interval or handshake shows as a pin that drops too early after `txn_end`, or that stays high after `cmd_ack`, within two clocks. The bench compares the flag byte and the pin against a requirement-level model on every cycle. Any divergence is therefore reported in the cycle it first becomes visible.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_EVT   = 5;
    localparam int FLAG_W    = 8;
    localparam int BIT_RSVD  = 5;
    localparam int BIT_EXT   = 6;
    localparam int BIT_BUSY  = 7;
    localparam int HOLD_CYC  = 1;
    localparam int HOLD_W    = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [FLAG_W-1:0] MASK_KEEP = 8'h5F;

    typedef struct packed {
        logic [NUM_EVT-1:0] flags;
    } evt_state_t;

    typedef struct packed {
        logic flag;
        logic en;
    } ext_state_t;

    typedef struct packed {
        logic              irq_n;
        logic [HOLD_W-1:0] hold;
        logic              ready;
    } pin_state_t;

    typedef struct packed {
        logic [FLAG_W-1:0] mask;
    } mask_state_t;
endpackage

// File: rtl/irqc_evt_flags.sv
module irqc_evt_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d;
    logic [N-1:0] flags_q;

    // event has priority over the clear of the same bit
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            flags_d[i] = evt[i] | (flags_q[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/irqc_ext.sv
module irqc_ext
    import irqc_pkg::*;
#(
    parameter int EN_BIT = BIT_EXT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              clr,
    input  logic              mask_we,
    input  logic [FLAG_W-1:0] mask_wdata,
    output logic              pending
);
    ext_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.flag = evt | (s_q.flag & ~clr);
        if (mask_we) s_d.en = mask_wdata[EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pending = s_q.flag & s_q.en;
endmodule

// File: rtl/irqc_pin.sv
module irqc_pin
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic txn_end,
    input  logic cmd_ack,
    output logic irq_n
);
    pin_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cmd_ack)      s_d.ready = 1'b1;
        else if (txn_end) s_d.ready = 1'b0;

        if (txn_end) begin
            s_d.irq_n = 1'b1;
            s_d.hold  = HOLD_W'(HOLD_CYC);
        end else if (s_q.hold != '0) begin
            s_d.irq_n = 1'b1;
            s_d.hold  = s_q.hold - 1'b1;
        end else begin
            s_d.irq_n = ~(pend | s_q.ready);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{irq_n: 1'b1, hold: '0, ready: 1'b0};
        else        s_q <= s_d;
    end

    assign irq_n = s_q.irq_n;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_frame,
    input  logic              evt_lost,
    input  logic              evt_win_chg,
    input  logic              evt_link,
    input  logic              evt_asc,
    input  logic              evt_meta,
    input  logic              busy_i,
    input  logic              mask_wr,
    input  logic [FLAG_W-1:0] mask_wdata,
    input  logic              ext_mask_wr,
    input  logic [FLAG_W-1:0] ext_mask_wdata,
    input  logic              dmx_read_done,
    input  logic              rd_status,
    input  logic              rd_frame_info,
    input  logic              rd_ext_flags,
    input  logic              txn_end,
    input  logic              cmd_ack,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_n_o
);
    logic [NUM_EVT-1:0] evt_vec, clr_vec, evt_flags;
    logic               ext_pend;
    logic               pend;
    mask_state_t        m_d, m_q;

    assign evt_vec = {evt_asc, evt_link, evt_win_chg, evt_lost, evt_frame};
    assign clr_vec = {rd_frame_info, rd_status, dmx_read_done, rd_status, dmx_read_done};

    irqc_evt_flags #(.N(NUM_EVT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_vec),
        .clr   (clr_vec),
        .flags (evt_flags)
    );

    irqc_ext #(.EN_BIT(BIT_EXT)) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_meta),
        .clr        (rd_ext_flags),
        .mask_we    (ext_mask_wr),
        .mask_wdata (ext_mask_wdata),
        .pending    (ext_pend)
    );

    always_comb begin
        m_d = m_q;
        if (mask_wr) m_d.mask = mask_wdata & MASK_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    always_comb begin
        flags_o                    = '0;
        flags_o[NUM_EVT-1:0]       = evt_flags;
        flags_o[BIT_EXT]           = ext_pend;
        flags_o[BIT_BUSY]          = busy_i;
    end

    assign pend = |(flags_o & m_q.mask);

    irqc_pin u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .txn_end (txn_end),
        .cmd_ack (cmd_ack),
        .irq_n   (irq_n_o)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_frame,
    input logic       evt_lost,
    input logic       evt_asc,
    input logic       rd_status,
    input logic       rd_frame_info,
    input logic       dmx_read_done,
    input logic       txn_end,
    input logic [7:0] flags_o,
    input logic       irq_n_o
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[5] == 1'b0); // R2
    AST_CLR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dmx_read_done && !evt_frame) |=> !flags_o[0]); // R3
    AST_CLR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !evt_lost) |=> !flags_o[1]); // R4
    AST_CLR_INFO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame_info && !evt_asc) |=> !flags_o[4]); // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_frame && dmx_read_done) |=> flags_o[0]); // R6
    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |=> irq_n_o); // R10
    AST_END_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_end, 2) |-> irq_n_o); // R10
endmodule

bind irq_flag_ctrl irqc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_frame     (evt_frame),
    .evt_lost      (evt_lost),
    .evt_asc       (evt_asc),
    .rd_status     (rd_status),
    .rd_frame_info (rd_frame_info),
    .dmx_read_done (dmx_read_done),
    .txn_end       (txn_end),
    .flags_o       (flags_o),
    .irq_n_o       (irq_n_o)
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_frame, evt_lost, evt_win_chg, evt_link, evt_asc, evt_meta, busy_i;
    logic mask_wr, ext_mask_wr;
    logic [7:0] mask_wdata, ext_mask_wdata;
    logic dmx_read_done, rd_status, rd_frame_info, rd_ext_flags, txn_end, cmd_ack;
    logic [7:0] flags_o;
    logic irq_n_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // reference model state
    logic [4:0] m_flags;
    logic       m_ext, m_ext_en, m_irq_n, m_ready;
    logic [7:0] m_mask;
    int         m_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl u_dut (.*);

    function automatic logic [7:0] exp_flags();
        return {busy_i, m_ext & m_ext_en, 1'b0, m_flags};
    endfunction

    function automatic logic exp_pend();
        logic [7:0] f;
        f = {1'b0, m_ext & m_ext_en, 1'b0, m_flags};
        return |(f & m_mask);
    endfunction

    task automatic clr_in();
        {evt_frame, evt_lost, evt_win_chg, evt_link, evt_asc, evt_meta} = '0;
        {mask_wr, ext_mask_wr, dmx_read_done, rd_status, rd_frame_info} = '0;
        {rd_ext_flags, txn_end, cmd_ack} = '0;
        mask_wdata = '0;
        ext_mask_wdata = '0;
    endtask

    task automatic model_reset();
        m_flags = '0; m_ext = 0; m_ext_en = 0; m_irq_n = 1; m_ready = 0;
        m_mask = '0; m_hold = 0;
    endtask

    task automatic model_tick();
        logic [4:0] ev, cl;
        logic p;
        p = exp_pend();
        if (txn_end) begin m_irq_n = 1; m_hold = 1; end
        else if (m_hold > 0) begin m_irq_n = 1; m_hold = m_hold - 1; end
        else m_irq_n = ~(p | m_ready);
        if (cmd_ack) m_ready = 1; else if (txn_end) m_ready = 0;
        ev = {evt_asc, evt_link, evt_win_chg, evt_lost, evt_frame};
        cl = {rd_frame_info, rd_status, dmx_read_done, rd_status, dmx_read_done};
        m_flags = ev | (m_flags & ~cl);
        m_ext = evt_meta | (m_ext & ~rd_ext_flags);
        if (ext_mask_wr) m_ext_en = ext_mask_wdata[6];
        if (mask_wr) m_mask = mask_wdata & 8'h5F;
    endtask

    task automatic compare(string tag);
        checks++;
        if (flags_o !== exp_flags()) begin
            fails++;
            $display("FAIL %s flags_o actual=%02h expected=%02h", tag, flags_o, exp_flags());
        end
        checks++;
        if (irq_n_o !== m_irq_n) begin
            fails++;
            $display("FAIL %s irq_n_o actual=%0b expected=%0b", tag, irq_n_o, m_irq_n);
        end
    endtask

    // inputs set at negedge before the call; outputs checked at next negedge
    task automatic step(string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare(tag);
        clr_in();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        clr_in();
        busy_i = 0;
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1;
        step("R1 idle");

        evt_frame = 1; step("R2 frame masked");
        step("R8 masked no pin");
        evt_lost = 1; evt_win_chg = 1; evt_link = 1; evt_asc = 1; step("R2 all events");
        mask_wr = 1; mask_wdata = 8'h01; step("R8 enable write");
        step("R8 pin falls");
        dmx_read_done = 1; step("R3 window clear");
        step("R3 pin after clear");
        rd_status = 1; step("R4 status clear");
        rd_frame_info = 1; step("R5 info clear");
        evt_frame = 1; dmx_read_done = 1; step("R6 tie");
        evt_asc = 1; rd_frame_info = 1; step("R6 tie asc");
        dmx_read_done = 1; rd_frame_info = 1; step("R6 cleanup");

        evt_meta = 1; step("R7 ext disabled");
        ext_mask_wr = 1; ext_mask_wdata = 8'h40; step("R7 ext enable");
        mask_wr = 1; mask_wdata = 8'h40; step("R7 summary enable");
        step("R7 pin low");
        evt_meta = 1; rd_ext_flags = 1; step("R7 tie");
        rd_ext_flags = 1; step("R7 ext clear");
        step("R7 pin release");

        mask_wr = 1; mask_wdata = 8'hFF; busy_i = 1; step("R9 busy write");
        step("R9 busy no pin");
        step("R9 busy hold");
        busy_i = 0;

        evt_link = 1; step("R10 pending");
        step("R10 pin low");
        txn_end = 1; step("R10 end high");
        step("R10 guard");
        step("R10 refall");
        rd_status = 1; step("R10 clear");
        step("R10 idle");

        cmd_ack = 1; step("R11 ack");
        step("R11 pin low");
        txn_end = 1; step("R11 end");
        step("R11 guard");
        step("R11 released");
        cmd_ack = 1; txn_end = 1; step("R11 tie");
        step("R11 tie guard");
        step("R11 tie low");
        txn_end = 1; step("R11 final end");

        for (int i = 0; i < 3000; i++) begin
            evt_frame     = ($urandom % 6) == 0;
            evt_lost      = ($urandom % 8) == 0;
            evt_win_chg   = ($urandom % 7) == 0;
            evt_link      = ($urandom % 9) == 0;
            evt_asc       = ($urandom % 8) == 0;
            evt_meta      = ($urandom % 10) == 0;
            busy_i        = ($urandom % 4) == 0;
            mask_wr       = ($urandom % 12) == 0;
            mask_wdata    = 8'($urandom);
            ext_mask_wr   = ($urandom % 15) == 0;
            ext_mask_wdata = 8'($urandom);
            dmx_read_done = ($urandom % 5) == 0;
            rd_status     = ($urandom % 5) == 0;
            rd_frame_info = ($urandom % 5) == 0;
            rd_ext_flags  = ($urandom % 6) == 0;
            txn_end       = ($urandom % 9) == 0;
            cmd_ack       = ($urandom % 14) == 0;
            step("R8 random");
        end
        finish_run();
    end
endmodule